// File: doc/BRIEF.md
# Polarity-Normalising Interrupt Front End

This block sits between up to 64 peripheral interrupt request lines and an upstream interrupt controller that only accepts active-high level requests. Software can invert each line's polarity, so active-low and falling-edge sources become active-high. It can also mask each line. For lines built as edge type, a detected edge is held in a pending latch, and software clears the latch by writing to an acknowledge register. Each output is therefore a steady high level while a request is outstanding.

Software reaches the block over a simple 16-bit register bus with byte addresses. Three register groups exist: mask, polarity and acknowledge. Each group holds one 16-bit word per block of 16 lines, and consecutive words sit 4 bytes apart. Parameters set the number of lines and which lines are edge type. A further parameter builds a variant with no acknowledge handling, in which every line passes its polarity-adjusted level straight through.

Top module: `irqfe_top`

## Requirements
- R1: After reset every mask, polarity and pending bit is 0. With all inputs low, every output is low and every register word reads 0.
- R2: Line n is at bit n mod 16 of the word at group base + 4*(n/16). The group bases are 0x00 for mask, 0x10 for polarity and 0x20 for acknowledge. A write to a mask or polarity word stores the implemented bits exactly, and a read returns them.
- R3: Bits of lines at or above NUM_LINES read 0 and are not stored. An address that is misaligned (low two bits not 0), that names a word past the last implemented one, that falls in the unused span at 0x30–0x3F, or that lies at 0x40 or above, is ignored on write and reads 0.
- R4: A mask bit of 1 forces that line's output low, and a mask bit of 0 passes the line through. While an edge line is masked its pending latch still sets, and the request appears once the line is unmasked.
- R5: A polarity bit of 1 inverts the line's input. A level line with polarity 1 outputs high while its input is low.
- R6: A level line's output follows its polarity-adjusted input in the same cycle, without passing through a register.
- R7: On an edge line, a rise of the adjusted input sets the pending latch. The output goes high from the next clock and stays high after the input returns low.
- R8: On an edge line with polarity 1, a falling input sets the latch and a rising input does not.
- R9: Writing 1 to a bit in the acknowledge group clears that edge line's latch. Bits written as 0 leave their latches unchanged. Reading an acknowledge word returns the pending bits of its edge lines, and level lines read 0.
- R10: When an edge arrives in the same cycle as an acknowledge of that line, the latch stays set.
- R11: With ACK_EN = 0, no line has a latch and every output follows its adjusted input. Writes to the acknowledge group have no effect, and the acknowledge group reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_LINES | Raw peripheral request lines |
| irq_out | output | NUM_LINES | Active-high level requests to the upstream controller |

## Verification
The hardest case to reach is the race in which an edge and an acknowledge of the same line land on the same clock. To build it, the bench first leaves a line pending. At one falling clock edge it then raises that line's input and starts the acknowledge write, so the rising clock edge that follows sees both events at once. The bench then checks that the output is still high, and that a later acknowledge on its own clears it. A second case is the spurious edge that appears when polarity is flipped on an edge line. The bench uses this on purpose: it clears that edge first, and only then shows that a falling input sets the latch while a rising input does not.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
   localparam int MAX_LINES = 64;
   localparam int BANK_W    = 16;
   localparam int MAX_WORDS = MAX_LINES / BANK_W;

   typedef enum logic [1:0] {
      GRP_MASK = 2'd0,
      GRP_POL  = 2'd1,
      GRP_ACK  = 2'd2,
      GRP_NONE = 2'd3
   } grp_e;

   function automatic int words_for(int lines);
      return (lines + BANK_W - 1) / BANK_W;
   endfunction
endpackage

// File: rtl/irqfe_decode.sv
module irqfe_decode
   import irqfe_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int WORDS  = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output grp_e              grp_o,
   output logic [1:0]        widx_o
);
   logic upper_zero;

   generate
      if (ADDR_W > 6) begin : g_upper
         assign upper_zero = (addr_i[ADDR_W-1:6] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      widx_o = addr_i[3:2];
      hit_o  = (addr_i[1:0] == 2'b00) && upper_zero &&
               (addr_i[5:4] != 2'd3) && (32'(addr_i[3:2]) < WORDS);
      grp_o  = hit_o ? grp_e'(addr_i[5:4]) : GRP_NONE;
   end
endmodule

// File: rtl/irqfe_cfg.sv
module irqfe_cfg
   import irqfe_pkg::*;
#(
   parameter int NUM_LINES = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wen_i,
   input  grp_e                 grp_i,
   input  logic [1:0]           widx_i,
   input  logic [BANK_W-1:0]    wdata_i,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [NUM_LINES-1:0] pol_o
);
   logic [NUM_LINES-1:0] mask_q, pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pol_q  <= '0;
      end else if (wen_i) begin
         for (int n = 0; n < NUM_LINES; n++) begin
            if (widx_i == 2'(n / BANK_W)) begin
               if (grp_i == GRP_MASK) mask_q[n] <= wdata_i[n % BANK_W];
               if (grp_i == GRP_POL)  pol_q[n]  <= wdata_i[n % BANK_W];
            end
         end
      end
   end

   assign mask_o = mask_q;
   assign pol_o  = pol_q;

   // R2: mask bits only move on a decoded mask write
   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wen_i && grp_i == GRP_MASK) |=> $stable(mask_q));

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
         localparam int W = n / BANK_W;
         localparam int B = n % BANK_W;
         // R2: a polarity write stores the written bit exactly
         p_pol_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wen_i && grp_i == GRP_POL && widx_i == 2'(W)) |=> (pol_q[n] == $past(wdata_i[B])));
      end
   endgenerate
endmodule

// File: rtl/irqfe_line.sv
module irqfe_line #(
   parameter bit IS_EDGE = 1'b0,
   parameter bit ACK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic mask_i,
   input  logic pol_i,
   input  logic ack_i,
   output logic irq_o,
   output logic pend_o
);
   logic adj;
   assign adj = raw_i ^ pol_i;

   generate
      if (IS_EDGE && ACK_EN) begin : g_edge
         logic adj_q, pend_q, rise;
         assign rise = adj & ~adj_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               adj_q  <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               adj_q <= adj;
               if (rise)       pend_q <= 1'b1;
               else if (ack_i) pend_q <= 1'b0;
            end
         end

         assign pend_o = pend_q;
         assign irq_o  = pend_q & ~mask_i;

         // R7 / R10: a detected edge always leaves the latch set, even against an acknowledge
         p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rise |=> pend_q);
         // R9: without an acknowledge a pending request is kept
         p_pend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && !ack_i) |=> pend_q);
         // R9: an acknowledge with no new edge clears the latch
         p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && ack_i && !rise) |=> !pend_q);
      end else begin : g_level
         assign pend_o = 1'b0;
         assign irq_o  = adj & ~mask_i;
      end
   endgenerate

   // R4: a masked line never drives its output
   p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i |-> !irq_o);
endmodule

// File: rtl/irqfe_top.sv
module irqfe_top
   import irqfe_pkg::*;
#(
   parameter int          NUM_LINES  = 40,
   parameter logic [63:0] EDGE_LINES = 64'h0000_00FF_FFFF_0000,
   parameter bit          ACK_EN     = 1'b1,
   parameter int          ADDR_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wen,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] irq_out
);
   localparam int WORDS = words_for(NUM_LINES);

   generate
      if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
         $error("irqfe_top: NUM_LINES must lie in 1..64");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("irqfe_top: ADDR_W must be at least 6");
      end
   endgenerate

   logic                 hit;
   grp_e                 grp;
   logic [1:0]           widx;
   logic [NUM_LINES-1:0] mask, pol, ack, pend;

   irqfe_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
      .addr_i (bus_addr),
      .hit_o  (hit),
      .grp_o  (grp),
      .widx_o (widx)
   );

   irqfe_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_i   (bus_wen),
      .grp_i   (grp),
      .widx_i  (widx),
      .wdata_i (bus_wdata),
      .mask_o  (mask),
      .pol_o   (pol)
   );

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
         localparam int W = n / BANK_W;
         localparam int B = n % BANK_W;
         assign ack[n] = bus_wen && (grp == GRP_ACK) && (widx == 2'(W)) && bus_wdata[B];

         irqfe_line #(.IS_EDGE(EDGE_LINES[n]), .ACK_EN(ACK_EN)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (irq_in[n]),
            .mask_i (mask[n]),
            .pol_i  (pol[n]),
            .ack_i  (ack[n]),
            .irq_o  (irq_out[n]),
            .pend_o (pend[n])
         );
      end
   endgenerate

   logic [MAX_LINES-1:0] mask_pad, pol_pad, pend_pad;
   assign mask_pad = MAX_LINES'(mask);
   assign pol_pad  = MAX_LINES'(pol);
   assign pend_pad = MAX_LINES'(pend);

   always_comb begin
      case (grp)
         GRP_MASK: bus_rdata = mask_pad[widx*BANK_W +: BANK_W];
         GRP_POL:  bus_rdata = pol_pad[widx*BANK_W +: BANK_W];
         GRP_ACK:  bus_rdata = pend_pad[widx*BANK_W +: BANK_W];
         default:  bus_rdata = '0;
      endcase
   end

   generate
      if (!ACK_EN) begin : g_noack_chk
         // R11: without acknowledge handling nothing is ever pending
         p_ack_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (grp == GRP_ACK) |-> (bus_rdata == 16'h0000));
      end
   endgenerate
endmodule

// File: tb/irqfe_top_test.sv
module irqfe_top_test;
   localparam int PERIOD = 10;
   localparam int NA = 40;
   localparam int NB = 20;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [15:0] data;
      logic [15:0] exp;
   } vec_t;

   // R2 / R3 register map vectors: write (optional) then read back
   localparam vec_t VEC [16] = '{
      '{1'b1, 8'h00, 16'hA5A5, 16'hA5A5},
      '{1'b1, 8'h02, 16'hFFFF, 16'h0000},
      '{1'b0, 8'h00, 16'h0000, 16'hA5A5},
      '{1'b1, 8'h04, 16'hFFFF, 16'hFFFF},
      '{1'b1, 8'h08, 16'hFFFF, 16'h00FF},
      '{1'b1, 8'h0C, 16'hFFFF, 16'h0000},
      '{1'b1, 8'h30, 16'hFFFF, 16'h0000},
      '{1'b1, 8'h10, 16'h1234, 16'h1234},
      '{1'b1, 8'h18, 16'hFF00, 16'h0000},
      '{1'b1, 8'h44, 16'hFFFF, 16'h0000},
      '{1'b0, 8'h04, 16'h0000, 16'hFFFF},
      '{1'b1, 8'h00, 16'h0000, 16'h0000},
      '{1'b1, 8'h04, 16'h0000, 16'h0000},
      '{1'b1, 8'h08, 16'h0000, 16'h0000},
      '{1'b1, 8'h10, 16'h0000, 16'h0000},
      '{1'b1, 8'h20, 16'hFFFF, 16'h0000}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic wen_a = 1'b0, wen_b = 1'b0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata_a, rdata_b;
   logic [NA-1:0] in_a = '0, out_a;
   logic [NB-1:0] in_b = '0, out_b;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   irqfe_top #(.NUM_LINES(NA)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wen(wen_a), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_in(in_a), .irq_out(out_a));

   irqfe_top #(.NUM_LINES(NB), .ACK_EN(1'b0)) uut_na (
      .clk(clk), .rst_n(rst_n), .bus_wen(wen_b), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_in(in_b), .irq_out(out_b));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit to_b, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d;
      if (to_b) wen_b = 1'b1; else wen_a = 1'b1;
      @(negedge clk);
      wen_a = 1'b0; wen_b = 1'b0;
   endtask

   task automatic rd_a(input logic [7:0] a, output logic [15:0] d);
      addr = a; #1; d = rdata_a;
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 outputs", 64'(out_a), 64'h0);
      rd_a(8'h00, r); check("R1 mask word", 64'(r), 64'h0);
      rd_a(8'h14, r); check("R1 polarity word", 64'(r), 64'h0);
      rd_a(8'h28, r); check("R1 ack word", 64'(r), 64'h0);

      // R2 / R3 table walk
      for (int i = 0; i < 16; i++) begin
         if (VEC[i].wr) wr(1'b0, VEC[i].addr, VEC[i].data);
         rd_a(VEC[i].addr, r);
         check($sformatf("R2/R3 vector %0d", i), 64'(r), 64'(VEC[i].exp));
      end
      check("R3 no stray request", 64'(out_a), 64'h0);

      // R7 / R9 edge line 16
      @(negedge clk); in_a[16] = 1'b1;
      @(negedge clk); check("R7 edge sets", 64'(out_a[16]), 64'h1);
      in_a[16] = 1'b0;
      @(negedge clk); check("R7 held after input drops", 64'(out_a[16]), 64'h1);
      rd_a(8'h24, r); check("R9 pending readback", 64'(r), 64'h0001);
      wr(1'b0, 8'h24, 16'h0000);
      check("R9 zero bits keep latch", 64'(out_a[16]), 64'h1);
      wr(1'b0, 8'h24, 16'h0001);
      check("R9 ack clears", 64'(out_a[16]), 64'h0);

      // R10 edge and ack in the same cycle, line 17
      @(negedge clk); in_a[17] = 1'b1;
      @(negedge clk); in_a[17] = 1'b0;
      @(negedge clk);
      in_a[17] = 1'b1; addr = 8'h24; wdata = 16'h0002; wen_a = 1'b1;
      @(negedge clk); wen_a = 1'b0;
      check("R10 edge wins over ack", 64'(out_a[17]), 64'h1);
      in_a[17] = 1'b0;
      wr(1'b0, 8'h24, 16'h0002);
      check("R10 later ack clears", 64'(out_a[17]), 64'h0);

      // R8 inverted edge line 18
      wr(1'b0, 8'h14, 16'h0004);
      wr(1'b0, 8'h24, 16'h0004);
      check("R8 cleared after polarity flip", 64'(out_a[18]), 64'h0);
      @(negedge clk); in_a[18] = 1'b1;
      @(negedge clk); check("R8 rising input ignored", 64'(out_a[18]), 64'h0);
      in_a[18] = 1'b0;
      @(negedge clk); check("R8 falling input sets", 64'(out_a[18]), 64'h1);
      wr(1'b0, 8'h24, 16'h0004);
      wr(1'b0, 8'h14, 16'h0000);
      check("R8 restored quiet", 64'(out_a[18]), 64'h0);

      // R4 masked edge line 19 keeps its request
      wr(1'b0, 8'h04, 16'h0008);
      @(negedge clk); in_a[19] = 1'b1;
      @(negedge clk); in_a[19] = 1'b0;
      @(negedge clk); check("R4 masked output low", 64'(out_a[19]), 64'h0);
      rd_a(8'h24, r); check("R4 pending while masked", 64'(r), 64'h0008);
      wr(1'b0, 8'h04, 16'h0000);
      check("R4 request after unmask", 64'(out_a[19]), 64'h1);
      wr(1'b0, 8'h24, 16'h0008);

      // R5 / R6 / R4 level lines
      @(negedge clk); in_a[5] = 1'b1; #1;
      check("R6 level follows same cycle", 64'(out_a[5]), 64'h1);
      rd_a(8'h20, r); check("R9 level line not pending", 64'(r), 64'h0);
      wr(1'b0, 8'h10, 16'h0040);
      check("R5 inverted level high on low input", 64'(out_a[6]), 64'h1);
      wr(1'b0, 8'h00, 16'h0020);
      check("R4 mask forces low", 64'(out_a[5]), 64'h0);
      in_a[5] = 1'b0;
      wr(1'b0, 8'h00, 16'h0000);
      wr(1'b0, 8'h10, 16'h0000);
      check("R5 all quiet again", 64'(out_a), 64'h0);

      // R2 last implemented line 39
      @(negedge clk); in_a[39] = 1'b1;
      @(negedge clk); in_a[39] = 1'b0;
      check("R2 line 39 set", 64'(out_a[39]), 64'h1);
      wr(1'b0, 8'h28, 16'h0080);
      check("R2 line 39 cleared via word 2 bit 7", 64'(out_a[39]), 64'h0);

      // R11 variant without acknowledge
      @(negedge clk); in_b[16] = 1'b1; #1;
      check("R11 edge line follows level", 64'(out_b[16]), 64'h1);
      wr(1'b1, 8'h24, 16'h0001);
      check("R11 ack write no effect", 64'(out_b[16]), 64'h1);
      addr = 8'h24; #1;
      check("R11 ack group reads 0", 64'(rdata_b), 64'h0);
      in_b[16] = 1'b0; #1;
      check("R11 output drops with input", 64'(out_b[16]), 64'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule